// File: doc/BRIEF.md
# Retriggerable Watchdog Reset Timer

This block is a down-counting watchdog that runs on the timer clock. A retrigger loads the counter with a programmable reload value. If the count reaches zero before the next retrigger, the block drives a reset request pulse of fixed length. After the pulse ends, the counter reloads itself and the watchdog keeps running.

A select input chooses where retriggers come from. In software mode, a one-cycle kick strobe is the retrigger. In pin mode, a rising edge on one of two raw external inputs is the retrigger. A second select input picks which of the two inputs is used. Each external input passes through a two-flop synchronizer and then a rising-edge detector before it can retrigger the counter. The block has no data stream, so every pin is a plain control or status signal and no handshake exists. Routing the reset request to the rest of the system is done outside this block.

The counter is cleared at reset. For that reason the enable should only be raised together with a kick, or after at least one disabled cycle, during which the counter follows the reload value.

Top module: `wdog_retrig_timer`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `rst_req` is 0.
- R2: In software mode (`kick_src`=0), if a kick is sampled at clock edge K with reload value N, `rst_req` stays 0 through edge K+N and rises at edge K+N+1.
- R3: Every reset request pulse is high for exactly 4 consecutive clock cycles.
- R4: After a pulse ends, the counter reloads and expires again without any kick, so pulses repeat every N+5 cycles.
- R5: A kick sampled before expiry reloads the counter, so kicks spaced at most N cycles apart hold `rst_req` at 0.
- R6: A kick that arrives while `rst_req` is high is ignored; the next pulse starts N+1 cycles after the end of the current one.
- R7: In pin mode (`kick_src`=1), a rising edge on `ext_in[pin_sel]` retriggers the counter at the third clock edge after the input first reads high.
- R8: In pin mode, `sw_kick` and any activity on the unselected input have no effect.
- R9: In software mode, edges on `ext_in` have no effect.
- R10: While `enable` is 0, no pulse starts and the counter follows the reload value.
- R11: A falling edge on the selected input does not retrigger.
- R12: With a reload value of 0, pulses repeat every 5 cycles (4 high, 1 low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Watchdog runs while high |
| reload_val | input | 16 | Value loaded on every retrigger and after every pulse |
| kick_src | input | 1 | Retrigger source: 0 = software kick, 1 = external pin edge |
| pin_sel | input | 1 | Selects which of the two external inputs is used in pin mode |
| sw_kick | input | 1 | One-cycle software retrigger strobe |
| ext_in | input | 2 | Raw asynchronous external inputs |
| rst_req | output | 1 | Reset request pulse, active high |

## Verification
The assertions assume that each external input holds its level for at least four timer clocks. The synchronizer and edge detector only see each change correctly when the input changes no faster than that. The bench keeps every high or low level on `ext_in` at least four cycles long. The assertions also assume that `sw_kick` is a clean synchronous strobe, so the bench drives all inputs just after the falling clock edge. The assertions do not cover the first count after reset, because the counter starts at zero. The bench therefore always raises `enable` together with a kick, or after disabled cycles that let the counter follow the reload value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    SRC_SOFT = 1'b0,
    SRC_PIN  = 1'b1
  } kick_src_e;

  localparam int DEF_CNT_W     = 16;
  localparam int DEF_N_PINS    = 2;
  localparam int DEF_SYNC_STG  = 2;
  localparam int DEF_PULSE_LEN = 4;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= raw_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/wdog_edge.sv
module wdog_edge #(
  parameter int W     = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     lvl,
  input  logic [SEL_W-1:0] sel,
  output logic             rise_evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise_all = lvl & ~prev_q;
  assign rise_evt = rise_all[sel];
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             kick,
  output logic             rst_req
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  pcnt_q;
  logic             pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else if (pulse_q) begin
      if (pcnt_q == '0) begin
        pulse_q <= 1'b0;
        cnt_q   <= reload_val;
      end else begin
        pcnt_q <= pcnt_q - 1'b1;
      end
    end else if (!enable || kick) begin
      cnt_q <= reload_val;
    end else if (cnt_q == '0) begin
      pulse_q <= 1'b1;
      pcnt_q  <= PC_LAST;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rst_req = pulse_q;
endmodule

// File: rtl/wdog_retrig_timer.sv
module wdog_retrig_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W       = DEF_CNT_W,
  parameter int N_PINS      = DEF_N_PINS,
  parameter int SYNC_STAGES = DEF_SYNC_STG,
  parameter int PULSE_LEN   = DEF_PULSE_LEN,
  parameter int SEL_W       = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic              kick_src,
  input  logic [SEL_W-1:0]  pin_sel,
  input  logic              sw_kick,
  input  logic [N_PINS-1:0] ext_in,
  output logic              rst_req
);
  logic [N_PINS-1:0] ext_sync;
  logic              pin_evt;
  logic              kick;

  wdog_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_in(ext_in), .sync_out(ext_sync)
  );

  wdog_edge #(.W(N_PINS), .SEL_W(SEL_W)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(ext_sync), .sel(pin_sel), .rise_evt(pin_evt)
  );

  always_comb begin
    case (kick_src_e'(kick_src))
      SRC_PIN: kick = pin_evt;
      default: kick = sw_kick;
    endcase
  end

  wdog_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) core_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reload_val(reload_val),
    .kick(kick), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_retrig_timer_chk.sv
module wdog_retrig_timer_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic kick_src,
  input logic sw_kick,
  input logic rst_req
);
  localparam int RW = $clog2(PULSE_LEN + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(PULSE_LEN + 1);
  localparam logic [RW-1:0] RUN_LEN = RW'(PULSE_LEN);

  logic [RW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           hi_run <= '0;
    else if (!rst_req)                    hi_run <= '0;
    else if (hi_run != RUN_MAX)           hi_run <= hi_run + 1'b1;
  end

  assert_pulse_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (hi_run < RUN_LEN));

  assert_pulse_full_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (hi_run == RUN_LEN));

  assert_kick_holds_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !kick_src && sw_kick && !rst_req) |=> !rst_req);

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !rst_req) |=> !rst_req);

  assert_start_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(enable));
endmodule

bind wdog_retrig_timer wdog_retrig_timer_chk #(.PULSE_LEN(PULSE_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .kick_src(kick_src),
  .sw_kick(sw_kick), .rst_req(rst_req)
);

// File: tb/wdog_retrig_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_retrig_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] reload_val = 16'd10;
  logic        kick_src = 1'b0;
  logic [0:0]  pin_sel = 1'b0;
  logic        sw_kick = 1'b0;
  logic [1:0]  ext_in = 2'b00;
  logic        rst_req;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  wdog_retrig_timer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .reload_val(reload_val),
    .kick_src(kick_src), .pin_sel(pin_sel), .sw_kick(sw_kick),
    .ext_in(ext_in), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor: pops expected items as their cycle comes up
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
      checks++; failures++;
      $display("FAIL %s cycle %0d missed actual=none expected=%0b",
               exp_q[0].tag, exp_q[0].cyc, exp_q[0].val);
      void'(exp_q.pop_front());
    end
    if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
      checks++;
      if (rst_req !== exp_q[0].val) begin
        failures++;
        $display("FAIL %s cycle %0d rst_req actual=%0b expected=%0b",
                 exp_q[0].tag, cyc, rst_req, exp_q[0].val);
      end
      void'(exp_q.pop_front());
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) step();
  endtask

  task automatic push_range(input int a, input int b, input logic v, input string tag);
    for (int i = a; i <= b; i++) begin
      exp_t e;
      e.cyc = i; e.val = v; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step();
  endtask

  task automatic settle();
    enable = 1'b0; sw_kick = 1'b0; ext_in = 2'b00;
    repeat (8) step();
  endtask

  task automatic pulse_kick_at(input int edge_cyc);
    wait_cyc(edge_cyc - 1);
    sw_kick = 1'b1;
    step();
    sw_kick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int k;
    int c;
    repeat (4) step();
    checks++;
    if (rst_req !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset actual=%0b expected=0", rst_req);
    end
    rst_n = 1'b1;
    step();
    checks++;
    if (rst_req !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset actual=%0b expected=0", rst_req);
    end
    repeat (2) step();

    // R2 / R3 / R4: software mode expiry and automatic repeat
    reload_val = 16'd10; step();
    k = cyc + 1;
    push_range(k, k + 10, 1'b0, "R2");
    push_range(k + 11, k + 14, 1'b1, "R3");
    push_range(k + 15, k + 25, 1'b0, "R4");
    push_range(k + 26, k + 29, 1'b1, "R4");
    push_range(k + 30, k + 30, 1'b0, "R4");
    enable = 1'b1; sw_kick = 1'b1; step(); sw_kick = 1'b0;
    drain(); settle();

    // R5: kicks every 8 cycles hold off the pulse
    k = cyc + 1;
    push_range(k, k + 34, 1'b0, "R5");
    push_range(k + 35, k + 38, 1'b1, "R5");
    push_range(k + 39, k + 39, 1'b0, "R5");
    enable = 1'b1; sw_kick = 1'b1; step(); sw_kick = 1'b0;
    for (int n = 1; n <= 3; n++) pulse_kick_at(k + 8 * n);
    drain(); settle();

    // R6: kick during the pulse is ignored
    reload_val = 16'd6; step();
    k = cyc + 1;
    push_range(k, k + 6, 1'b0, "R6");
    push_range(k + 7, k + 10, 1'b1, "R6");
    push_range(k + 11, k + 17, 1'b0, "R6");
    push_range(k + 18, k + 18, 1'b1, "R6");
    enable = 1'b1; sw_kick = 1'b1; step(); sw_kick = 1'b0;
    pulse_kick_at(k + 8);
    drain(); settle();

    // R12: reload of zero
    reload_val = 16'd0; step();
    k = cyc + 1;
    push_range(k, k, 1'b0, "R12");
    push_range(k + 1, k + 4, 1'b1, "R12");
    push_range(k + 5, k + 5, 1'b0, "R12");
    push_range(k + 6, k + 9, 1'b1, "R12");
    push_range(k + 10, k + 10, 1'b0, "R12");
    enable = 1'b1; sw_kick = 1'b1; step(); sw_kick = 1'b0;
    drain(); settle();

    // R10: disabled, nothing starts despite kicks and pin edges
    reload_val = 16'd3; step();
    c = cyc;
    push_range(c + 1, c + 30, 1'b0, "R10");
    for (int n = 0; n < 30; n++) begin
      sw_kick = (n % 3 == 0);
      ext_in = ((n / 5) % 2 == 1) ? 2'b11 : 2'b00;
      step();
    end
    sw_kick = 1'b0;
    drain(); settle();

    // R9: software mode ignores pin edges
    reload_val = 16'd10; step();
    k = cyc + 1;
    push_range(k, k + 10, 1'b0, "R9");
    push_range(k + 11, k + 14, 1'b1, "R9");
    push_range(k + 15, k + 15, 1'b0, "R9");
    kick_src = 1'b0; enable = 1'b1; sw_kick = 1'b1; step(); sw_kick = 1'b0;
    wait_cyc(k + 2); ext_in = 2'b11;
    wait_cyc(k + 6); ext_in = 2'b00;
    wait_cyc(k + 10); ext_in = 2'b11;
    drain(); settle();

    // R7 / R8 / R11: pin mode on input 0
    kick_src = 1'b1; pin_sel = 1'b0; step();
    c = cyc; k = c + 3;
    push_range(c + 1, k + 3, 1'b0, "R7");
    push_range(k + 4, k + 10, 1'b0, "R8 R11");
    push_range(k + 11, k + 14, 1'b1, "R7");
    push_range(k + 15, k + 15, 1'b0, "R7");
    enable = 1'b1; ext_in = 2'b01;
    wait_cyc(c + 4); ext_in = 2'b10;
    pulse_kick_at(k + 6);
    wait_cyc(c + 9); ext_in = 2'b00;
    drain(); settle();

    // R7: pin mode on input 1
    pin_sel = 1'b1; step();
    c = cyc; k = c + 3;
    push_range(c + 1, k + 10, 1'b0, "R7");
    push_range(k + 11, k + 14, 1'b1, "R7");
    push_range(k + 15, k + 15, 1'b0, "R7");
    enable = 1'b1; ext_in = 2'b10;
    wait_cyc(c + 4); ext_in = 2'b01;
    wait_cyc(c + 9); ext_in = 2'b00;
    drain(); settle();
    kick_src = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule